// File: doc/BRIEF.md
# Per-Byte Data Bus Inversion Codec

This block encodes and decodes data bus inversion on a data path that is split into byte lanes, with one flag signal per lane. The transmit side counts the ones in every lane and, when inversion is enabled for the current direction, sends a lane that has more ones than zeros complemented, with that lane's flag raised. Because the lines are terminated low, this keeps the number of lines driven high small. The receive side takes a data beat and its flags and restores the original bytes.

Read and write traffic have separate inversion enables, and each side picks one through a direction input. In a masked write the flag pin does double duty. With write inversion off, the flag simply marks a lane as not to be written. With write inversion on, the flag keeps its inversion meaning, and a masked lane is signalled by a pattern that a real inversion never produces: flag high with all data lines high. Every beat is handled on its own, with no memory of earlier beats. The encoder output is registered; the decoder is combinational.

Both sides decode their controls into one of four operating modes through the same selector. The modes are PASS (no inversion, no mask), INVERT (count-based inversion), MASK (flag carries the byte mask) and MASK_INVERT (inversion with mask as an invalid pattern). The transitions are selected every beat: a masked write goes to MASK or MASK_INVERT depending on the write enable, a plain beat goes to PASS or INVERT depending on the enable for its direction, and a read beat never enters a masked mode.

Top module: `dbi_codec`

## Requirements
- R1: While rst_n is low, and in the first cycle after it, enc_data and enc_flag are all zero.
- R2: The encoder has one cycle of latency; in PASS mode enc_data equals the input beat and every enc_flag bit is 0.
- R3: In INVERT mode, lane i (data bits [8i+7:8i], flag bit i) with five or more ones is sent complemented with flag 1; a lane with four or fewer ones, exactly four included, is sent unchanged with flag 0; lanes are decided independently.
- R4: A side with its write input at 1 uses wr_inv_en; with it at 0 it uses rd_inv_en.
- R5: In a masked write with write inversion off, enc_flag bit i equals tx_byte_mask bit i (1 = do not write) and the data passes unchanged.
- R6: In a masked write with write inversion on, a masked lane is sent as all ones with flag 1, and an unmasked lane is encoded as in R3.
- R7: The masked input has no effect in the read direction: the encoder behaves as in PASS or INVERT and the decoder holds every dec_lane_we bit at 1.
- R8: The decoder is combinational; in INVERT mode a lane with flag 1 is complemented, a lane with flag 0 passes, and its lane enable is 1.
- R9: In PASS mode the decoder passes the data unchanged whatever the flags, with every lane enable at 1.
- R10: In MASK mode a lane with flag 1 has dec_lane_we 0, a lane with flag 0 has it 1, and data passes unchanged.
- R11: In MASK_INVERT mode a lane with flag 1 and four or more ones is masked (enable 0, output byte 0); a lane with flag 1 and three or fewer ones is complemented with enable 1.
- R12: Each beat is encoded independently of the beats before it, so back-to-back beats of different patterns each follow R2 to R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the encoder output register |
| rst_n | input | 1 | Active-low reset |
| wr_inv_en | input | 1 | Inversion enable for the write direction |
| rd_inv_en | input | 1 | Inversion enable for the read direction |
| tx_write | input | 1 | Encoder beat direction: 1 write, 0 read |
| tx_masked | input | 1 | Encoder beat belongs to a masked write |
| tx_byte_mask | input | 2 | Per-lane mask, 1 = lane not to be written |
| tx_data | input | 16 | Beat to encode |
| enc_data | output | 16 | Encoded beat, registered |
| enc_flag | output | 2 | Per-lane flag, registered |
| rx_write | input | 1 | Decoder beat direction: 1 write, 0 read |
| rx_masked | input | 1 | Decoder beat belongs to a masked write |
| rx_data | input | 16 | Received beat |
| rx_flag | input | 2 | Received per-lane flags |
| dec_data | output | 16 | Restored beat |
| dec_lane_we | output | 2 | Per-lane write enable, 0 = lane masked |

## Verification
The bench builds the block with its default of a 16-bit path in 8-bit lanes, so there are two lanes and the flag width is two. That is enough to give the two lanes opposite decisions in the same beat and to place one lane exactly on the four-versus-five ones boundary while the other sits far from it. With 8-bit lanes the masked pattern (all ones) and the largest inverted count (three ones) are far apart, so the decoder's four-or-more rule can be probed at exactly four.

// File: rtl/dbi_pkg.sv
package dbi_pkg;

    typedef enum logic [1:0] {
        MODE_PASS        = 2'd0,
        MODE_INVERT      = 2'd1,
        MODE_MASK        = 2'd2,
        MODE_MASK_INVERT = 2'd3
    } dbi_mode_e;

endpackage

// File: rtl/dbi_mode_sel.sv
module dbi_mode_sel
    import dbi_pkg::*;
(
    input  logic      wr_inv_en,
    input  logic      rd_inv_en,
    input  logic      is_write,
    input  logic      masked,
    output dbi_mode_e mode
);

    logic inv_on;
    logic mask_on;

    always_comb begin
        inv_on  = is_write ? wr_inv_en : rd_inv_en;
        mask_on = is_write & masked;
        unique case ({mask_on, inv_on})
            2'b00:   mode = MODE_PASS;
            2'b01:   mode = MODE_INVERT;
            2'b10:   mode = MODE_MASK;
            2'b11:   mode = MODE_MASK_INVERT;
            default: mode = MODE_PASS;
        endcase
    end

endmodule

// File: rtl/dbi_lane_enc.sv
module dbi_lane_enc
    import dbi_pkg::*;
#(
    parameter int LANE_W = 8
) (
    input  dbi_mode_e         mode,
    input  logic [LANE_W-1:0] data_in,
    input  logic              mask_in,
    output logic [LANE_W-1:0] data_out,
    output logic              flag_out
);

    localparam int CNT_W   = $clog2(LANE_W + 1);
    localparam int INV_MIN = LANE_W / 2 + 1;

    logic [CNT_W-1:0] ones;
    logic             heavy;

    always_comb begin
        ones = '0;
        for (int b = 0; b < LANE_W; b++) begin
            ones = ones + CNT_W'(data_in[b]);
        end
        heavy = (ones >= CNT_W'(INV_MIN));
    end

    always_comb begin
        unique case (mode)
            MODE_PASS: begin
                data_out = data_in;
                flag_out = 1'b0;
            end
            MODE_INVERT: begin
                data_out = heavy ? ~data_in : data_in;
                flag_out = heavy;
            end
            MODE_MASK: begin
                data_out = data_in;
                flag_out = mask_in;
            end
            MODE_MASK_INVERT: begin
                if (mask_in) begin
                    data_out = '1;
                    flag_out = 1'b1;
                end else begin
                    data_out = heavy ? ~data_in : data_in;
                    flag_out = heavy;
                end
            end
            default: begin
                data_out = data_in;
                flag_out = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/dbi_lane_dec.sv
module dbi_lane_dec
    import dbi_pkg::*;
#(
    parameter int LANE_W = 8
) (
    input  dbi_mode_e         mode,
    input  logic [LANE_W-1:0] data_in,
    input  logic              flag_in,
    output logic [LANE_W-1:0] data_out,
    output logic              we_out
);

    localparam int CNT_W    = $clog2(LANE_W + 1);
    localparam int MASK_MIN = LANE_W / 2;

    logic [CNT_W-1:0] ones;
    logic             bad_inv;

    always_comb begin
        ones = '0;
        for (int b = 0; b < LANE_W; b++) begin
            ones = ones + CNT_W'(data_in[b]);
        end
        bad_inv = (ones >= CNT_W'(MASK_MIN));
    end

    always_comb begin
        unique case (mode)
            MODE_PASS: begin
                data_out = data_in;
                we_out   = 1'b1;
            end
            MODE_INVERT: begin
                data_out = flag_in ? ~data_in : data_in;
                we_out   = 1'b1;
            end
            MODE_MASK: begin
                data_out = data_in;
                we_out   = ~flag_in;
            end
            MODE_MASK_INVERT: begin
                if (flag_in && bad_inv) begin
                    data_out = '0;
                    we_out   = 1'b0;
                end else begin
                    data_out = flag_in ? ~data_in : data_in;
                    we_out   = 1'b1;
                end
            end
            default: begin
                data_out = data_in;
                we_out   = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/dbi_codec.sv
module dbi_codec
    import dbi_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int LANE_W = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_inv_en,
    input  logic                         rd_inv_en,
    input  logic                         tx_write,
    input  logic                         tx_masked,
    input  logic [DATA_W/LANE_W-1:0]     tx_byte_mask,
    input  logic [DATA_W-1:0]            tx_data,
    output logic [DATA_W-1:0]            enc_data,
    output logic [DATA_W/LANE_W-1:0]     enc_flag,
    input  logic                         rx_write,
    input  logic                         rx_masked,
    input  logic [DATA_W-1:0]            rx_data,
    input  logic [DATA_W/LANE_W-1:0]     rx_flag,
    output logic [DATA_W-1:0]            dec_data,
    output logic [DATA_W/LANE_W-1:0]     dec_lane_we
);

    localparam int LANES   = DATA_W / LANE_W;
    localparam int INV_MIN = LANE_W / 2 + 1;

    dbi_mode_e tx_mode;
    dbi_mode_e rx_mode;

    logic [DATA_W-1:0] enc_data_next;
    logic [LANES-1:0]  enc_flag_next;
    logic              past_ok;

    dbi_mode_sel u_tx_mode (
        .wr_inv_en (wr_inv_en),
        .rd_inv_en (rd_inv_en),
        .is_write  (tx_write),
        .masked    (tx_masked),
        .mode      (tx_mode)
    );

    dbi_mode_sel u_rx_mode (
        .wr_inv_en (wr_inv_en),
        .rd_inv_en (rd_inv_en),
        .is_write  (rx_write),
        .masked    (rx_masked),
        .mode      (rx_mode)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        dbi_lane_enc #(.LANE_W(LANE_W)) u_enc (
            .mode     (tx_mode),
            .data_in  (tx_data[g*LANE_W +: LANE_W]),
            .mask_in  (tx_byte_mask[g]),
            .data_out (enc_data_next[g*LANE_W +: LANE_W]),
            .flag_out (enc_flag_next[g])
        );

        dbi_lane_dec #(.LANE_W(LANE_W)) u_dec (
            .mode     (rx_mode),
            .data_in  (rx_data[g*LANE_W +: LANE_W]),
            .flag_in  (rx_flag[g]),
            .data_out (dec_data[g*LANE_W +: LANE_W]),
            .we_out   (dec_lane_we[g])
        );

        // R3: flag follows the ones count of the beat one cycle earlier
        assert_inv_decision_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (past_ok && $past(tx_mode) == MODE_INVERT) |->
            (enc_flag[g] == ($countones($past(tx_data[g*LANE_W +: LANE_W])) >= INV_MIN)))
            else $error("inversion decision wrong on lane %0d", g);

        // R6: an unmasked lane in an inverting mode never drives more than half its lines high
        assert_inv_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (past_ok && ($past(tx_mode) == MODE_INVERT ||
                         ($past(tx_mode) == MODE_MASK_INVERT && !$past(tx_byte_mask[g])))) |->
            ($countones(enc_data[g*LANE_W +: LANE_W]) <= LANE_W / 2))
            else $error("too many ones on lane %0d", g);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enc_data <= '0;
            enc_flag <= '0;
            past_ok  <= 1'b0;
        end else begin
            enc_data <= enc_data_next;
            enc_flag <= enc_flag_next;
            past_ok  <= 1'b1;
        end
    end

    // R2: plain mode passes the previous beat with flags low
    assert_pass_through_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(tx_mode) == MODE_PASS) |->
        (enc_flag == '0 && enc_data == $past(tx_data)))
        else $error("pass-through mismatch");

    // R5: mask-only mode carries the byte mask on the flags
    assert_mask_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(tx_mode) == MODE_MASK) |->
        (enc_flag == $past(tx_byte_mask) && enc_data == $past(tx_data)))
        else $error("mask flag mismatch");

    // R7: read-direction decoding never masks a lane
    assert_read_all_we_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_write |-> (&dec_lane_we))
        else $error("lane masked on a read beat");

endmodule

// File: tb/dbi_codec_tb.sv
module dbi_codec_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 10;
    localparam int WD_CYCLES  = 5000;

    // vector fields: [39] wr_en [38] rd_en [37] write [36] masked
    // [35:34] mask [33:18] data [17:2] expected data [1:0] expected flag
    localparam logic [39:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 16'hFFFF, 16'hFFFF, 2'b00},
        {1'b1, 1'b0, 1'b1, 1'b0, 2'b00, 16'hFF0F, 16'h000F, 2'b10},
        {1'b1, 1'b0, 1'b1, 1'b0, 2'b00, 16'h1FF0, 16'hE0F0, 2'b10},
        {1'b1, 1'b0, 1'b1, 1'b0, 2'b00, 16'h0737, 16'h07C8, 2'b01},
        {1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 16'hFFFF, 16'h0000, 2'b11},
        {1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 16'hFFFF, 16'hFFFF, 2'b00},
        {1'b0, 1'b0, 1'b1, 1'b1, 2'b01, 16'hABCD, 16'hABCD, 2'b01},
        {1'b1, 1'b0, 1'b1, 1'b1, 2'b10, 16'h12F8, 16'hFF07, 2'b11},
        {1'b1, 1'b0, 1'b1, 1'b1, 2'b00, 16'h3C01, 16'h3C01, 2'b00},
        {1'b0, 1'b1, 1'b0, 1'b1, 2'b11, 16'hFE00, 16'h0100, 2'b10}
    };

    string vec_tag [NVEC] = '{"R2", "R3", "R3", "R3", "R4", "R4",
                              "R5", "R6", "R6", "R7"};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_inv_en = 1'b0;
    logic        rd_inv_en = 1'b0;
    logic        tx_write = 1'b0;
    logic        tx_masked = 1'b0;
    logic [1:0]  tx_byte_mask = '0;
    logic [15:0] tx_data = '0;
    logic [15:0] enc_data;
    logic [1:0]  enc_flag;
    logic        rx_write = 1'b0;
    logic        rx_masked = 1'b0;
    logic [15:0] rx_data = '0;
    logic [1:0]  rx_flag = '0;
    logic [15:0] dec_data;
    logic [1:0]  dec_lane_we;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dbi_codec dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_inv_en    (wr_inv_en),
        .rd_inv_en    (rd_inv_en),
        .tx_write     (tx_write),
        .tx_masked    (tx_masked),
        .tx_byte_mask (tx_byte_mask),
        .tx_data      (tx_data),
        .enc_data     (enc_data),
        .enc_flag     (enc_flag),
        .rx_write     (rx_write),
        .rx_masked    (rx_masked),
        .rx_data      (rx_data),
        .rx_flag      (rx_flag),
        .dec_data     (dec_data),
        .dec_lane_we  (dec_lane_we)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic dec_case(input string req, input logic wr, input logic rd,
                            input logic wdir, input logic msk,
                            input logic [15:0] d, input logic [1:0] f,
                            input logic [15:0] exp_d, input logic [1:0] exp_we);
        wr_inv_en = wr;
        rd_inv_en = rd;
        rx_write  = wdir;
        rx_masked = msk;
        rx_data   = d;
        rx_flag   = f;
        #1;
        chk({req, " dec data"}, {16'h0, dec_data}, {16'h0, exp_d});
        chk({req, " dec we"}, {30'h0, dec_lane_we}, {30'h0, exp_we});
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: outputs held at zero under reset even with heavy input
        wr_inv_en = 1'b1;
        tx_write  = 1'b1;
        tx_data   = 16'hFFFF;
        repeat (3) @(negedge clk);
        chk("R1 reset data", {16'h0, enc_data}, 32'h0);
        chk("R1 reset flag", {30'h0, enc_flag}, 32'h0);
        rst_n = 1'b1;

        // vector table, one beat per cycle back to back (R12)
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            wr_inv_en    = VEC[i][39];
            rd_inv_en    = VEC[i][38];
            tx_write     = VEC[i][37];
            tx_masked    = VEC[i][36];
            tx_byte_mask = VEC[i][35:34];
            tx_data      = VEC[i][33:18];
            @(posedge clk);
            #1;
            chk({vec_tag[i], " R12 enc data"}, {16'h0, enc_data}, {16'h0, VEC[i][17:2]});
            chk({vec_tag[i], " R12 enc flag"}, {30'h0, enc_flag}, {30'h0, VEC[i][1:0]});
        end

        // R2: one cycle of latency, output not yet changed before the edge
        @(negedge clk);
        wr_inv_en = 1'b0; rd_inv_en = 1'b0; tx_write = 1'b1; tx_masked = 1'b0;
        tx_data = 16'h5AA5;
        @(posedge clk); #1;
        @(negedge clk);
        tx_data = 16'h0F0F;
        #1;
        chk("R2 hold before edge", {16'h0, enc_data}, 32'h5AA5);
        @(posedge clk); #1;
        chk("R2 after edge", {16'h0, enc_data}, 32'h0F0F);

        // decoder, combinational
        @(negedge clk);
        dec_case("R8", 1'b0, 1'b1, 1'b0, 1'b0, 16'h00FF, 2'b10, 16'hFFFF, 2'b11);
        dec_case("R8 flag low", 1'b1, 1'b0, 1'b1, 1'b0, 16'h00FF, 2'b00, 16'h00FF, 2'b11);
        dec_case("R9", 1'b0, 1'b0, 1'b0, 1'b0, 16'h1234, 2'b11, 16'h1234, 2'b11);
        dec_case("R10", 1'b0, 1'b1, 1'b1, 1'b1, 16'h5A5A, 2'b01, 16'h5A5A, 2'b10);
        dec_case("R11", 1'b1, 1'b0, 1'b1, 1'b1, 16'hFF07, 2'b11, 16'h00F8, 2'b01);
        dec_case("R11 four ones", 1'b1, 1'b0, 1'b1, 1'b1, 16'h000F, 2'b01, 16'h0000, 2'b10);
        dec_case("R7 dec read", 1'b0, 1'b0, 1'b0, 1'b1, 16'h1234, 2'b11, 16'h1234, 2'b11);
        dec_case("R4 dec dir", 1'b0, 1'b1, 1'b1, 1'b0, 16'hF00F, 2'b11, 16'hF00F, 2'b11);

        // R1: reset applied mid-run clears the registered outputs
        @(negedge clk);
        wr_inv_en = 1'b0; tx_write = 1'b1; tx_masked = 1'b0; tx_data = 16'hC3C3;
        @(posedge clk); #1;
        chk("R1 pre-reset", {16'h0, enc_data}, 32'hC3C3);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R1 mid reset", {16'h0, enc_data}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule